// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames on a single line. An oversampling enable pulses sixteen times per bit period. Each frame has one start bit, eight data bits sent least significant bit first, an optional parity bit, and one or two stop bits. Four static inputs set the frame format: receive enable, parity enable, odd/even select and stop-bit count. Each received byte goes into a data register, and a full flag announces it. Software reaches both through a small register bus with a read strobe, a write strobe and a one-bit address.

Two sticky flags report errors: one for parity and one for framing. A frame with an error is still stored in the data register, but it does not raise the full flag. While either error flag is set, the receiver refuses every new frame. Software clears a flag in two steps: it reads the status register while that flag is 1, and it later writes 0 to that bit. A reset or the standby input clears both flags.

Top module: `uart_err_rx`

## Requirements
- R1: A well-formed frame loads the eight data bits, first received bit into bit 0, into the data register at address 1. It also sets the full flag, which is bit 0 of the status register at address 0.
- R2: A bus read of the data register clears the full flag.
- R3: If the first stop bit is sampled low, the framing flag (status bit 2) sets. The byte is still written to the data register, and the full flag stays 0.
- R4: With two stop bits selected, the second stop bit is not checked. A low second stop bit leaves the frame good, and a low first stop bit is still a framing error.
- R5: With parity enabled, the number of ones in the data bits plus the parity bit must be even when odd select is 0 and odd when it is 1. A mismatch sets the parity flag (status bit 1).
- R6: On a parity error the byte is still written to the data register, and the full flag stays 0.
- R7: While either error flag is 1, no frame is received. The data register and the full flag do not change.
- R8: An error flag clears only when a status read has returned that flag as 1 and a later status write has 0 in that bit. A write of 0 with no earlier read of 1 does nothing, and a write of 1 does nothing. Each flag keeps its own read record.
- R9: Reset clears the data register, the full flag and both error flags. The standby input clears both error flags.
- R10: With receive enable low, no frame is received. Lowering receive enable leaves both error flags unchanged.
- R11: A start bit counts only if the line is still low at the middle of the start bit. A shorter low pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Clears both error flags and idles the receiver |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | Parity bit present and checked |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| rd_en | input | 1 | Bus read strobe |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 1 | 0 selects status, 1 selects data |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, combinational on addr |

## Verification
The bench sends every byte value under a rotating mix of parity and stop-bit settings. It then sends frames with a wrong parity bit, a low first stop bit, a low second stop bit and a too-short start pulse.

Several faults are targeted:
- A receiver that checks the second stop bit would raise a false framing error.
- A receiver that ignores the sticky flags would overwrite the stored bad byte with a later frame.
- Flag logic that skips the read-then-write rule would clear on the first write of 0.
- Flag logic with one shared read record would let one flag's read unlock the other.
- A receiver that starts on a glitch would store a garbage byte.

// File: rtl/uart_rxe_pkg.sv
package uart_rxe_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_STOP2
    } rx_state_e;

    typedef struct packed {
        logic rx_en;
        logic par_en;
        logic odd;
        logic two_stop;
    } rx_cfg_t;

    localparam int  ERR_PAR     = 0;
    localparam int  ERR_FRM     = 1;
    localparam int  NUM_ERR     = 2;
    localparam int  ST_FULL_BIT = 0;
    localparam int  ST_ERR_BASE = 1;
    localparam logic ADDR_STAT  = 1'b0;
    localparam logic ADDR_DATA  = 1'b1;

    function automatic logic parity_bad(input logic ones_xor, input logic pbit, input logic odd);
        return (ones_xor ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/rxe_line_sync.sv
module rxe_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= {q[STAGES-2:0], din};
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/rxe_frame_fsm.sv
module rxe_frame_fsm
    import uart_rxe_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 abort,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 blocked,
    input  logic                 par_en,
    input  logic                 two_stop,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 pbit,
    output logic                 stop_ok
);
    localparam int HALF  = OVERSAMPLE / 2;
    localparam int LAST2 = OVERSAMPLE + HALF - 2;
    localparam int CW    = $clog2(OVERSAMPLE + HALF);
    localparam int IW    = $clog2(DATA_BITS);

    rx_state_e st;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RX_IDLE;
            cnt     <= '0;
            idx     <= '0;
            done    <= 1'b0;
            data    <= '0;
            pbit    <= 1'b0;
            stop_ok <= 1'b1;
        end else begin
            done <= 1'b0;
            if (abort) begin
                st  <= RX_IDLE;
                cnt <= '0;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
                unique case (st)
                    RX_IDLE: begin
                        cnt <= '0;
                        if (!line && !blocked) st <= RX_START;
                    end
                    RX_START: if (cnt == CW'(HALF - 1)) begin
                        cnt <= '0;
                        idx <= '0;
                        st  <= line ? RX_IDLE : RX_DATA;
                    end
                    RX_DATA: if (cnt == CW'(OVERSAMPLE - 1)) begin
                        cnt  <= '0;
                        data <= {line, data[DATA_BITS-1:1]};
                        if (idx == IW'(DATA_BITS - 1)) st <= par_en ? RX_PAR : RX_STOP;
                        else idx <= idx + 1'b1;
                    end
                    RX_PAR: if (cnt == CW'(OVERSAMPLE - 1)) begin
                        cnt  <= '0;
                        pbit <= line;
                        st   <= RX_STOP;
                    end
                    RX_STOP: if (cnt == CW'(OVERSAMPLE - 1)) begin
                        cnt     <= '0;
                        done    <= 1'b1;
                        stop_ok <= line;
                        st      <= two_stop ? RX_STOP2 : RX_IDLE;
                    end
                    RX_STOP2: if (cnt == CW'(LAST2)) begin
                        cnt <= '0;
                        st  <= RX_IDLE;
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    p_block_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (blocked && st == RX_IDLE) |=> st == RX_IDLE);

    p_done_after_stop_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(st) == RX_STOP);
endmodule

// File: rtl/rxe_flag_cell.sv
module rxe_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic flag
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (wr_hit && !wr_bit && armed) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (rd_hit && flag) begin
            armed <= 1'b1;
        end
    end

    p_clear_needs_arm_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(clr || (wr_hit && !wr_bit && armed)));
endmodule

// File: rtl/uart_err_rx.sv
module uart_err_rx
    import uart_rxe_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 standby,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 rx_en,
    input  logic                 par_en,
    input  logic                 odd_par,
    input  logic                 two_stop,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic                 addr,
    input  logic [DATA_BITS-1:0] wdata,
    output logic [DATA_BITS-1:0] rdata
);
    rx_cfg_t cfg;
    assign cfg = '{rx_en: rx_en, par_en: par_en, odd: odd_par, two_stop: two_stop};

    logic                 line_s;
    logic                 fr_done, fr_pbit, fr_stop_ok;
    logic [DATA_BITS-1:0] fr_data;
    logic [NUM_ERR-1:0]   err_set, err_q;
    logic [DATA_BITS-1:0] data_q;
    logic                 full_q;
    logic                 stat_rd, stat_wr, data_rd;
    logic                 unused_wbits;

    assign unused_wbits = ^wdata;
    assign stat_rd = rd_en && (addr == ADDR_STAT);
    assign stat_wr = wr_en && (addr == ADDR_STAT);
    assign data_rd = rd_en && (addr == ADDR_DATA);

    rxe_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
    );

    rxe_frame_fsm #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_fsm (
        .clk(clk), .rst(rst), .abort(standby || !cfg.rx_en), .tick(os_tick),
        .line(line_s), .blocked(|err_q), .par_en(cfg.par_en), .two_stop(cfg.two_stop),
        .done(fr_done), .data(fr_data), .pbit(fr_pbit), .stop_ok(fr_stop_ok)
    );

    assign err_set[ERR_PAR] = fr_done && cfg.par_en && parity_bad(^fr_data, fr_pbit, cfg.odd);
    assign err_set[ERR_FRM] = fr_done && !fr_stop_ok;

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_flag
        rxe_flag_cell u_flag (
            .clk(clk), .rst(rst), .clr(standby), .set(err_set[g]),
            .rd_hit(stat_rd), .wr_hit(stat_wr), .wr_bit(wdata[ST_ERR_BASE+g]),
            .flag(err_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (fr_done) data_q <= fr_data;
            if (fr_done && !(|err_set)) full_q <= 1'b1;
            else if (data_rd)           full_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_DATA) begin
            rdata = data_q;
        end else begin
            rdata[ST_FULL_BIT]             = full_q;
            rdata[ST_ERR_BASE +: NUM_ERR] = err_q;
        end
    end

    p_full_clean_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(full_q) |-> err_q == '0);

    p_flags_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !standby && !stat_wr && !fr_done) |=> $stable(err_q));

    p_blocked_data_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(|err_q) && |err_q && !standby) |-> $stable(data_q));
endmodule

// File: tb/sim_uart_err_rx.sv
module sim_uart_err_rx;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic standby = 1'b0, os_tick = 1'b0, rxd = 1'b1;
    logic rx_en = 1'b1, par_en = 1'b0, odd_par = 1'b0, two_stop = 1'b0;
    logic rd_en = 1'b0, wr_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;
    always @(posedge clk) os_tick <= ~os_tick;

    uart_err_rx u0 (
        .clk(clk), .rst(rst), .standby(standby), .os_tick(os_tick), .rxd(rxd),
        .rx_en(rx_en), .par_en(par_en), .odd_par(odd_par), .two_stop(two_stop),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic bus_wr(input logic [7:0] v);
        @(negedge clk);
        addr = 1'b0; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bit_out(input logic v);
        rxd = v;
        repeat (32) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par, input bit s1, input bit s2);
        @(negedge clk);
        bit_out(1'b0);
        for (int k = 0; k < 8; k++) bit_out(d[k]);
        if (par_en) bit_out((^d) ^ odd_par ^ bad_par);
        bit_out(s1);
        if (two_stop) bit_out(s2);
        bit_out(1'b1);
        bit_out(1'b1);
    endtask

    task automatic pulse_standby();
        @(negedge clk); standby = 1'b1;
        @(negedge clk); standby = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        finished = 1;
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        bus_rd(1'b0, v); chk("R9 reset status", v, 0);
        bus_rd(1'b1, v); chk("R9 reset data", v, 0);

        // R1 R2 R5: every byte under rotating format settings
        for (int i = 0; i < 256; i++) begin
            par_en = i[0] ^ i[4]; odd_par = i[1]; two_stop = i[2] ^ i[5];
            send(8'(i), 0, 1, 1);
            bus_rd(1'b0, v); chk("R1/R5 full after good frame", v, 1);
            bus_rd(1'b1, v); chk("R1 data", v, i);
            bus_rd(1'b0, v); chk("R2 full cleared by data read", v, 0);
        end

        // R3 framing error, R7 blocking, R8 clear protocol
        par_en = 0; two_stop = 0;
        send(8'hA5, 0, 0, 1);
        bus_wr(8'h00);
        send(8'h3C, 0, 1, 1);
        bus_rd(1'b0, v); chk("R8 unarmed write 0 / R3 framing flag", v, 4);
        bus_rd(1'b1, v); chk("R3/R7 errored byte kept", v, 8'hA5);
        bus_wr(8'h04);
        bus_rd(1'b0, v); chk("R8 write 1 ignored", v, 4);
        bus_wr(8'h00);
        bus_rd(1'b0, v); chk("R8 read-then-write clears", v, 0);
        send(8'h3C, 0, 1, 1);
        bus_rd(1'b0, v); chk("R7 reception resumes", v, 1);
        bus_rd(1'b1, v); chk("R7 new data", v, 8'h3C);

        // R6 parity error, even parity
        par_en = 1; odd_par = 0;
        send(8'h0F, 1, 1, 1);
        bus_rd(1'b0, v); chk("R6 parity flag, no full", v, 2);
        bus_rd(1'b1, v); chk("R6 byte stored", v, 8'h0F);
        pulse_standby();
        bus_rd(1'b0, v); chk("R9 standby clears", v, 0);

        // R8 per-flag: both errors, clear only parity
        send(8'h81, 1, 0, 1);
        bus_rd(1'b0, v); chk("R8 both flags", v, 6);
        bus_wr(8'h04);
        bus_rd(1'b0, v); chk("R8 only parity cleared", v, 4);
        bus_wr(8'h00);
        bus_rd(1'b0, v); chk("R8 framing cleared", v, 0);

        // R5 odd parity mismatch
        odd_par = 1;
        send(8'h33, 1, 1, 1);
        bus_rd(1'b0, v); chk("R5 odd parity error", v, 2);
        pulse_standby();

        // R4 second stop ignored, first stop checked
        par_en = 0; two_stop = 1;
        send(8'h5E, 0, 1, 0);
        bus_rd(1'b0, v); chk("R4 low second stop accepted", v, 1);
        bus_rd(1'b1, v); chk("R4 data", v, 8'h5E);
        send(8'h11, 0, 0, 1);
        bus_rd(1'b0, v); chk("R4 low first stop is framing", v, 4);
        pulse_standby();
        two_stop = 0;

        // R10 receive disabled
        rx_en = 0;
        send(8'h77, 0, 1, 1);
        bus_rd(1'b0, v); chk("R10 disabled no full", v, 0);
        bus_rd(1'b1, v); chk("R10 disabled data kept", v, 8'h11);
        rx_en = 1;
        send(8'h22, 0, 0, 1);
        rx_en = 0;
        repeat (50) @(negedge clk);
        bus_rd(1'b0, v); chk("R10 flags kept when disabled", v, 4);
        rx_en = 1;
        pulse_standby();

        // R11 short low glitch
        @(negedge clk);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (128) @(negedge clk);
        bus_rd(1'b0, v); chk("R11 glitch ignored status", v, 0);
        bus_rd(1'b1, v); chk("R11 glitch data kept", v, 8'h22);
        send(8'hC3, 0, 1, 1);
        bus_rd(1'b1, v); chk("R11 next frame ok", v, 8'hC3);

        report();
    end
endmodule